// File: doc/BRIEF.md
# Vector Floating-Point Round-to-Integral Unit

This unit takes a packed vector of IEEE-754 values, 64 or 128 bits wide, and rounds every lane to an integral value in the same floating-point format. Lanes are half (16-bit), single (32-bit) or double (64-bit) precision. A single rounding-mode input applies to all lanes. The unit returns the packed result one clock later. It also returns an inexact flag and an invalid flag, each ORed over the lanes in use.

A separate half-precision select overrides the size select. The size select doubles the lane width from 32 to 64 bits, and the wide select doubles the vector from 64 to 128 bits. Double lanes in a 64-bit vector are an illegal setting. For that setting the unit raises an undefined-configuration output and keeps its previous result.

Top module: `fp_vec_roundint`

## Requirements
- R1: Lane width is 16 when `half_i`=1; otherwise it is 32, or 64 when `dbl_i`=1. Vector width is 128 when `wide_i`=1 and 64 otherwise. Lane i occupies bits [i*W +: W] of both `src_i` and `dst_o`. When the vector is 64 bits wide, `dst_o[127:64]` is zero and the upper source bits affect nothing.
- R2: When `half_i`=0, `dbl_i`=1 and `wide_i`=0, `undef_o` goes to 1. In that case `dst_o` keeps its previous value and both flags are 0. Otherwise `undef_o` is 0.
- R3: `rmode_i` encodes the rounding direction: 00 nearest with ties to even, 01 toward +infinity, 10 toward -infinity, 11 toward zero. It is applied to every finite non-integral lane.
- R4: A nonzero finite value with magnitude below 1, subnormals included, rounds to ±0 or ±1 as the mode directs. The result always keeps the input sign, so -0.3 toward +infinity gives -0.
- R5: A finite value that is already integral, including every value whose unbiased exponent is at least the fraction width, is returned unchanged and raises no flag.
- R6: A zero or an infinity is returned unchanged with its sign and raises no flag.
- R7: A signaling NaN (top fraction bit 0, fraction nonzero) is returned with the top fraction bit set and raises `invalid_o`. A quiet NaN is returned unchanged with no flag.
- R8: `inexact_o` is 1 exactly when at least one active lane's result differs numerically from its input.
- R9: Results and flags appear on the clock edge after the inputs are presented. Reset clears `dst_o` and all three flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 128 | Packed source lanes |
| half_i | input | 1 | Select 16-bit lanes (overrides `dbl_i`) |
| dbl_i | input | 1 | Select 64-bit lanes instead of 32-bit |
| wide_i | input | 1 | 128-bit vector when 1, 64-bit when 0 |
| rmode_i | input | 2 | Rounding direction (R3 encoding) |
| dst_o | output | 128 | Packed rounded lanes |
| inexact_o | output | 1 | Some active lane changed value |
| invalid_o | output | 1 | Some active lane held a signaling NaN |
| undef_o | output | 1 | Illegal size setting was presented |

## Verification
Random lanes are drawn from several classes: zeros, infinities, both NaN kinds, subnormals, huge exponents, and exponents just around the integral boundary. Because those classes are mixed within one vector, the flag ORing is tested against lanes that do change and lanes that do not. Directed values such as 2.5, 3.5, -2.5 and 0.5 separate ties-to-even from the other three directions. The value -0.3 shows that the sign is kept when the result is zero. Narrow vectors with junk in the upper half and illegal settings placed between legal ones show that unused bits are ignored and that the previous result is held.

// File: rtl/fp_vec_roundint.sv
module fp_vec_roundint #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] src_i,
  input  logic          half_i,
  input  logic          dbl_i,
  input  logic          wide_i,
  input  logic [1:0]    rmode_i,
  output logic [VW-1:0] dst_o,
  output logic          inexact_o,
  output logic          invalid_o,
  output logic          undef_o
);
  localparam int NH = VW / 16;
  localparam int NS = VW / 32;
  localparam int ND = VW / 64;

  // returns {inexact, invalid, value}
  function automatic logic [65:0] rnd(input logic [63:0] x, input int ew, input int fw,
                                      input logic [1:0] m);
    logic [63:0] ex, fr, mant, mask, rem, half, trunc, newm, val, sgn;
    int bias, e, k;
    logic up, nx, nv;
    sgn  = 64'(x[ew+fw]) << (ew + fw);
    ex   = (x >> fw) & ((64'd1 << ew) - 64'd1);
    fr   = x & ((64'd1 << fw) - 64'd1);
    bias = (1 << (ew - 1)) - 1;
    e    = int'(ex) - bias;
    val  = x;
    nx   = 1'b0;
    nv   = 1'b0;
    up   = 1'b0;
    mant = 64'd0; mask = 64'd0; rem = 64'd0; half = 64'd0; trunc = 64'd0; newm = 64'd0;
    k    = 0;
    if (ex == (64'd1 << ew) - 64'd1) begin
      if (fr != 64'd0 && !fr[fw-1]) begin
        nv  = 1'b1;
        val = x | (64'd1 << (fw - 1));
      end
    end else if (ex == 64'd0 && fr == 64'd0) begin
      val = x;
    end else if (e >= fw) begin
      val = x;
    end else if (e < 0) begin
      nx = 1'b1;
      case (m)
        2'b00: up = (e == -1) && (fr != 64'd0);
        2'b01: up = !x[ew+fw];
        2'b10: up = x[ew+fw];
        default: up = 1'b0;
      endcase
      val = up ? (sgn | (64'(bias) << fw)) : sgn;
    end else begin
      k     = fw - e;
      mant  = fr | (64'd1 << fw);
      mask  = (64'd1 << k) - 64'd1;
      rem   = mant & mask;
      trunc = mant & ~mask;
      half  = 64'd1 << (k - 1);
      nx    = rem != 64'd0;
      case (m)
        2'b00: up = (rem > half) || (rem == half && mant[k]);
        2'b01: up = nx && !x[ew+fw];
        2'b10: up = nx && x[ew+fw];
        default: up = 1'b0;
      endcase
      newm = trunc + (up ? (64'd1 << k) : 64'd0);
      if (newm[fw+1])
        val = sgn | ((ex + 64'd1) << fw);
      else
        val = sgn | (ex << fw) | (newm & ((64'd1 << fw) - 64'd1));
    end
    return {nx, nv, val};
  endfunction

  logic [VW-1:0] hres, sres, dres, nxt;
  logic [NH-1:0] hnx, hnv;
  logic [NS-1:0] snx, snv;
  logic [ND-1:0] dnx, dnv;

  for (genvar i = 0; i < NH; i++) begin : g_half
    logic [65:0] t;
    logic unused_hi;
    assign t = rnd({48'd0, src_i[i*16 +: 16]}, 5, 10, rmode_i);
    assign {hnx[i], hnv[i], hres[i*16 +: 16]} = {t[65:64], t[15:0]};
    assign unused_hi = ^t[63:16];
  end
  for (genvar i = 0; i < NS; i++) begin : g_single
    logic [65:0] t;
    logic unused_hi;
    assign t = rnd({32'd0, src_i[i*32 +: 32]}, 8, 23, rmode_i);
    assign {snx[i], snv[i], sres[i*32 +: 32]} = {t[65:64], t[31:0]};
    assign unused_hi = ^t[63:32];
  end
  for (genvar i = 0; i < ND; i++) begin : g_double
    logic [65:0] t;
    assign t = rnd(src_i[i*64 +: 64], 11, 52, rmode_i);
    assign {dnx[i], dnv[i], dres[i*64 +: 64]} = t;
  end

  logic [NH-1:0] hmask;
  logic [NS-1:0] smask;
  logic [ND-1:0] dmask;
  logic bad, nx_any, nv_any;
  logic [VW-1:0] sel;

  assign hmask = wide_i ? {NH{1'b1}} : {{(NH/2){1'b0}}, {(NH/2){1'b1}}};
  assign smask = wide_i ? {NS{1'b1}} : {{(NS/2){1'b0}}, {(NS/2){1'b1}}};
  assign dmask = wide_i ? {ND{1'b1}} : {{(ND/2){1'b0}}, {(ND/2){1'b1}}};
  assign bad    = !half_i && dbl_i && !wide_i;
  assign sel    = half_i ? hres : (dbl_i ? dres : sres);
  assign nxt    = wide_i ? sel : {{(VW/2){1'b0}}, sel[VW/2-1:0]};
  assign nx_any = half_i ? |(hnx & hmask) : (dbl_i ? |(dnx & dmask) : |(snx & smask));
  assign nv_any = half_i ? |(hnv & hmask) : (dbl_i ? |(dnv & dmask) : |(snv & smask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_o     <= '0;
      inexact_o <= 1'b0;
      invalid_o <= 1'b0;
      undef_o   <= 1'b0;
    end else begin
      undef_o   <= bad;
      inexact_o <= !bad && nx_any;
      invalid_o <= !bad && nv_any;
      if (!bad) dst_o <= nxt;
    end
  end

  AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) undef_o |-> dst_o == $past(dst_o)); // R2
  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) undef_o |-> !inexact_o && !invalid_o); // R2
  AST_UNDEF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) undef_o |-> $past(dbl_i && !wide_i && !half_i)); // R2
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n) (!undef_o && !$past(wide_i)) |-> dst_o[VW-1:VW/2] == '0); // R1
endmodule

// File: tb/fp_vec_roundint_bench.sv
`timescale 1ns/1ps
module fp_vec_roundint_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [127:0] src = '0, dst;
  logic half = 1'b0, dbl = 1'b0, wide = 1'b0;
  logic [1:0] rm = 2'b00;
  logic inexact, invalid, undef;
  int checks = 0, errors = 0;
  logic [127:0] last_dst = '0;

  always #2 clk = ~clk;

  fp_vec_roundint u_fp_vec_roundint (
    .clk(clk), .rst_n(rst_n), .src_i(src), .half_i(half), .dbl_i(dbl), .wide_i(wide),
    .rmode_i(rm), .dst_o(dst), .inexact_o(inexact), .invalid_o(invalid), .undef_o(undef));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic real pow2(input int n);
    real p = 1.0;
    if (n >= 0) repeat (n) p = p * 2.0;
    else repeat (-n) p = p / 2.0;
    return p;
  endfunction

  // model: {inexact, invalid, value}
  function automatic logic [65:0] ref_lane(input logic [63:0] x, input int ew, input int fw,
                                           input logic [1:0] m);
    int w = 1 + ew + fw, bias = (1 << (ew - 1)) - 1, e;
    logic s = x[w-1];
    logic [63:0] ex = (x >> fw) & ((64'd1 << ew) - 1), fr = x & ((64'd1 << fw) - 1), frq;
    real v, f, r, mm;
    if (ex == (64'd1 << ew) - 1) begin
      if (fr != 0 && !fr[fw-1]) return {1'b0, 1'b1, x | (64'd1 << (fw - 1))};
      return {2'b00, x};
    end
    if (ex == 0 && fr == 0) return {2'b00, x};
    if (ex == 0) v = real'(fr) * pow2(1 - bias - fw);
    else v = real'(fr | (64'd1 << fw)) * pow2(int'(ex) - bias - fw);
    f = $floor(v);
    case (m)
      2'b00: r = (v - f > 0.5) ? f + 1.0 : (v - f < 0.5) ? f :
                 (($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0);
      2'b01: r = s ? f : $ceil(v);
      2'b10: r = s ? $ceil(v) : f;
      default: r = f;
    endcase
    if (r == 0.0) return {r != v, 1'b0, 64'(s) << (w - 1)};
    mm = r; e = 0;
    while (mm >= 2.0) begin mm = mm / 2.0; e++; end
    frq = 64'(longint'((mm - 1.0) * pow2(fw)));
    return {r != v, 1'b0, (64'(s) << (w - 1)) | (64'(e + bias) << fw) | frq};
  endfunction

  task automatic expect_vec(input logic [127:0] s_i, input logic h, input logic d, input logic wd,
                            input logic [1:0] m, output logic [127:0] ed, output logic enx,
                            output logic env, output logic eun);
    int ew, fw, w, n;
    logic [65:0] t;
    eun = !h && d && !wd;
    ed = '0; enx = 1'b0; env = 1'b0;
    if (eun) begin ed = last_dst; return; end
    if (h) begin ew = 5; fw = 10; end
    else if (d) begin ew = 11; fw = 52; end
    else begin ew = 8; fw = 23; end
    w = 1 + ew + fw;
    n = (wd ? 128 : 64) / w;
    for (int i = 0; i < n; i++) begin
      t = ref_lane(64'((s_i >> (i * w)) & ((128'd1 << w) - 1)), ew, fw, m);
      ed = ed | (128'(t[63:0]) << (i * w));
      enx = enx | t[65];
      env = env | t[64];
    end
  endtask

  task automatic apply(input logic [127:0] s_i, input logic h, input logic d, input logic wd,
                       input logic [1:0] m);
    logic [127:0] ed; logic enx, env, eun;
    expect_vec(s_i, h, d, wd, m, ed, enx, env, eun);
    src = s_i; half = h; dbl = d; wide = wd; rm = m;
    @(posedge clk); #1;
    chk(eun ? "R2 dst held" : "R3/R5/R6/R7 dst", dst, ed);
    chk("R8 inexact", 128'(inexact), 128'(enx));
    chk("R7 invalid", 128'(invalid), 128'(env));
    chk("R2 undef", 128'(undef), 128'(eun));
    last_dst = ed;
  endtask

  task automatic direct(input string req, input logic [127:0] s_i, input logic h, input logic d,
                        input logic wd, input logic [1:0] m, input logic [127:0] ed,
                        input logic enx, input logic env);
    src = s_i; half = h; dbl = d; wide = wd; rm = m;
    @(posedge clk); #1;
    chk(req, dst, ed);
    chk({req, " inexact R8"}, 128'(inexact), 128'(enx));
    chk({req, " invalid R7"}, 128'(invalid), 128'(env));
    last_dst = ed;
  endtask

  function automatic logic [63:0] gen_lane(input int ew, input int fw);
    int bias = (1 << (ew - 1)) - 1;
    logic [63:0] fr = {$urandom, $urandom} & ((64'd1 << fw) - 1);
    logic [63:0] ex, s = 64'($urandom % 2);
    case ($urandom % 12)
      0: begin ex = 0; fr = 0; end
      1: begin ex = (64'd1 << ew) - 1; fr = 0; end
      2: begin ex = (64'd1 << ew) - 1; fr = fr | (64'd1 << (fw - 1)); end
      3: begin ex = (64'd1 << ew) - 1; fr = (fr & ~(64'd1 << (fw - 1))) | 64'd1; end
      4: ex = 0;
      5: ex = 64'(bias + fw + ($urandom % 4));
      6: ex = 64'($urandom % bias);
      default: ex = 64'(bias - 2 + int'($urandom % (fw + 4)));
    endcase
    return (s << (ew + fw)) | (ex << fw) | fr;
  endfunction

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #9;
    chk("R9 reset dst", dst, '0);
    chk("R9 reset flags", {125'd0, inexact, invalid, undef}, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R3 ties and directions, single lanes, lane 1 = 1.0 exact
    direct("R3 2.5 RNE", {64'hDEAD_BEEF_0123_4567, 32'h3F800000, 32'h40200000}, 0, 0, 0, 2'b00,
           {64'd0, 32'h3F800000, 32'h40000000}, 1, 0);
    direct("R3 3.5 RNE", {64'd0, 32'h3F800000, 32'h40600000}, 0, 0, 0, 2'b00,
           {64'd0, 32'h3F800000, 32'h40800000}, 1, 0);
    direct("R3 -2.5 RM", {64'd0, 32'h3F800000, 32'hC0200000}, 0, 0, 0, 2'b10,
           {64'd0, 32'h3F800000, 32'hC0400000}, 1, 0);
    direct("R3 2.5 RZ", {64'd0, 32'h3F800000, 32'h40200000}, 0, 0, 0, 2'b11,
           {64'd0, 32'h3F800000, 32'h40000000}, 1, 0);
    direct("R4 -0.3 RP", {64'd0, 32'h3F800000, 32'hBE99999A}, 0, 0, 0, 2'b01,
           {64'd0, 32'h3F800000, 32'h80000000}, 1, 0);
    direct("R4 half 0.5 RNE", {112'd0, 16'h3800}, 1, 0, 0, 2'b00, 128'd0, 1, 0);
    direct("R4 half 0.5 RP", {112'd0, 16'h3800}, 1, 0, 0, 2'b01, {112'd0, 16'h3C00}, 1, 0);
    direct("R5 2^23+1 unchanged", {64'd0, 32'h3F800000, 32'h4B000001}, 0, 0, 0, 2'b01,
           {64'd0, 32'h3F800000, 32'h4B000001}, 0, 0);
    direct("R6 -inf and -0", {64'd0, 32'hFF800000, 32'h80000000}, 0, 0, 0, 2'b00,
           {64'd0, 32'hFF800000, 32'h80000000}, 0, 0);
    direct("R7 sNaN quieted", {64'd0, 32'h7FC00005, 32'h7F800001}, 0, 0, 0, 2'b00,
           {64'd0, 32'h7FC00005, 32'h7FC00001}, 0, 1);
    direct("R1 double wide 1.5", {64'h4000000000000000, 64'h3FF8000000000000}, 0, 1, 1, 2'b00,
           {64'h4000000000000000, 64'h4000000000000000}, 1, 0);
    apply({$urandom, $urandom, $urandom, $urandom}, 0, 1, 0, 2'b00); // R2 illegal setting
    for (int n = 0; n < 600; n++) begin
      logic h, d, wd;
      logic [127:0] s_v;
      int ew, fw, w;
      h = ($urandom % 3) == 0;
      d = $urandom % 2;
      wd = ($urandom % 8) != 0 || h || !d;
      if ($urandom % 20 == 0) begin h = 0; d = 1; wd = 0; end
      if (h) begin ew = 5; fw = 10; end
      else if (d) begin ew = 11; fw = 52; end
      else begin ew = 8; fw = 23; end
      w = 1 + ew + fw;
      s_v = {$urandom, $urandom, $urandom, $urandom};
      for (int i = 0; i < 128 / w; i++)
        s_v = (s_v & ~(((128'd1 << w) - 1) << (i * w))) | (128'(gen_lane(ew, fw)) << (i * w));
      apply(s_v, h, d, wd, 2'($urandom % 4));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule